// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the combinational interlock and bypass controller of a five-stage in-order integer core (fetch, decode, execute, memory, writeback). Each cycle it compares the register indices read by the instructions in decode and execute with the destinations held in the three downstream pipeline registers. From that comparison it selects bypass sources for the two ALU operands, for the store-data path and for the branch comparator in decode. When no bypass can cover a dependency, it freezes the front of the pipe for one cycle.

The core writes the register file only in writeback and reads it only in decode, so only read-after-write dependencies reach this block. Register index 0 is hard-wired to zero and never counts as a producer. Branches are resolved in decode. As a result, a branch that needs a value from the ALU instruction directly ahead of it waits one cycle. A branch that needs a value from a load directly ahead of it waits two cycles.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each ALU operand select (`alu_a_sel` for `ex_rs1`, `alu_b_sel` for `ex_rs2`) is 2'b10 when the execute-to-memory register writes that index. It is 2'b01 when only the memory-to-writeback register writes it. It is 2'b00, meaning the register file, when neither does. The code 2'b11 is never produced.
- R2: When both downstream registers write the same source index, the ALU select picks the younger execute-to-memory result (2'b10).
- R3: A destination index of 0 never causes a bypass, a stall or a store-data select, whatever the write enables say.
- R4: A load in execute whose destination equals `id_rs1`, or equals `id_rs2` of a decode instruction that is not a store, raises `stall_hold` and `idex_bubble` for that cycle.
- R5: A store in decode whose data register (`id_rs2`) equals the destination of a load in execute, while `id_rs1` does not, causes no stall. Once the store reaches memory, `st_data_sel` is 1 when `mem_is_store` is set and `mem_rs2` equals the nonzero writeback destination with `wb_reg_we` set. Otherwise it is 0.
- R6: A branch in decode whose `id_rs1` or `id_rs2` equals the nonzero destination of any register-writing instruction in execute stalls.
- R7: A branch in decode whose source equals the nonzero destination of a load held in the execute-to-memory register stalls. This makes two stall cycles in total behind a load.
- R8: The branch selects (`br_a_sel` for `id_rs1`, `br_b_sel` for `id_rs2`) are 2'b10 for a matching non-load in the execute-to-memory register. Otherwise they are 2'b01 for a match in memory-to-writeback, and 2'b00 when there is no match.
- R9: `stall_hold` and `idex_bubble` are always equal, and both are 0 when none of the conditions in R4, R6 or R7 holds.
- R10: A write enable of 0 on a downstream register removes that register from every bypass and stall decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | First source index of the decode instruction |
| id_rs2 | input | AW | Second source index of the decode instruction |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_is_store | input | 1 | Decode instruction is a store (rs2 is data) |
| ex_rs1 | input | AW | First source index in execute |
| ex_rs2 | input | AW | Second source index in execute |
| ex_rd | input | AW | Destination index in execute |
| ex_reg_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination index in execute-to-memory register |
| mem_reg_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_rs2 | input | AW | Store-data index of the memory-stage instruction |
| wb_rd | input | AW | Destination index in memory-to-writeback register |
| wb_reg_we | input | 1 | Writeback instruction writes a register |
| alu_a_sel | output | 2 | Bypass select for ALU operand A |
| alu_b_sel | output | 2 | Bypass select for ALU operand B |
| st_data_sel | output | 1 | Store data taken from writeback value |
| br_a_sel | output | 2 | Bypass select for branch operand A in decode |
| br_b_sel | output | 2 | Bypass select for branch operand B in decode |
| stall_hold | output | 1 | Hold PC and the fetch-to-decode register |
| idex_bubble | output | 1 | Load a no-op into the decode-to-execute register |

## Verification
The assertions assume that the flag inputs describe a legal instruction mix. A load always has its register write enable set, and a store never has a write enable. The sweep generates flags so that they obey this: loads force `*_reg_we` high and stores force it low. Register indices are drawn from a small range that includes 0, so that index collisions and zero-destination cases occur often. A thin bench-side mux then checks that the operand each select picks equals the value of the youngest producer.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF   = 2'b00,
    SRC_WB   = 2'b01,
    SRC_MEM  = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int AW = 5,
  parameter bit SKIP_MEM_LOAD = 1'b0
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_ld,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    sel
);
  logic mem_ok;
  logic mem_hit;
  logic wb_hit;

  generate
    if (SKIP_MEM_LOAD) begin : g_gate
      assign mem_ok = mem_we && !mem_ld;
    end else begin : g_plain
      assign mem_ok = mem_we;
    end
  endgenerate

  assign mem_hit = mem_ok && (mem_rd != '0) && (mem_rd == src);
  assign wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);

  always_comb begin
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_is_branch,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_reg_we,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_reg_we,
  input  logic          mem_is_load,
  output logic          stall
);
  logic ex_live, mem_ld_live;
  logic ex_m1, ex_m2, mem_m1, mem_m2;
  logic load_use, br_ex, br_mem;

  assign ex_live     = ex_reg_we && (ex_rd != '0);
  assign mem_ld_live = mem_reg_we && mem_is_load && (mem_rd != '0);

  assign ex_m1  = ex_live && (ex_rd == id_rs1);
  assign ex_m2  = ex_live && (ex_rd == id_rs2);
  assign mem_m1 = mem_ld_live && (mem_rd == id_rs1);
  assign mem_m2 = mem_ld_live && (mem_rd == id_rs2);

  // store data register is bypassed later, so only its address source counts
  assign load_use = ex_is_load && (ex_m1 || (ex_m2 && !id_is_store));
  assign br_ex    = id_is_branch && (ex_m1 || ex_m2);
  assign br_mem   = id_is_branch && (mem_m1 || mem_m2);

  assign stall = load_use || br_ex || br_mem;
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_is_branch,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_reg_we,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_reg_we,
  input  logic          mem_is_load,
  input  logic          mem_is_store,
  input  logic [AW-1:0] mem_rs2,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_reg_we,
  output logic [1:0]    alu_a_sel,
  output logic [1:0]    alu_b_sel,
  output logic          st_data_sel,
  output logic [1:0]    br_a_sel,
  output logic [1:0]    br_b_sel,
  output logic          stall_hold,
  output logic          idex_bubble
);
  localparam int NSRC = 4;
  localparam int NALU = 2;

  logic [AW-1:0] src_idx [NSRC];
  logic [1:0]    src_sel [NSRC];
  logic          stall;

  assign src_idx[0] = ex_rs1;
  assign src_idx[1] = ex_rs2;
  assign src_idx[2] = id_rs1;
  assign src_idx[3] = id_rs2;

  // ALU sources take any EX/MEM result; decode branch sources skip a load there
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      hz_fwd_pick #(
        .AW            (AW),
        .SKIP_MEM_LOAD (i >= NALU)
      ) u_pick (
        .src    (src_idx[i]),
        .mem_rd (mem_rd),
        .mem_we (mem_reg_we),
        .mem_ld (mem_is_load),
        .wb_rd  (wb_rd),
        .wb_we  (wb_reg_we),
        .sel    (src_sel[i])
      );
    end
  endgenerate

  hz_interlock #(.AW(AW)) u_lock (
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_is_branch (id_is_branch),
    .id_is_store  (id_is_store),
    .ex_rd        (ex_rd),
    .ex_reg_we    (ex_reg_we),
    .ex_is_load   (ex_is_load),
    .mem_rd       (mem_rd),
    .mem_reg_we   (mem_reg_we),
    .mem_is_load  (mem_is_load),
    .stall        (stall)
  );

  assign alu_a_sel   = src_sel[0];
  assign alu_b_sel   = src_sel[1];
  assign br_a_sel    = src_sel[2];
  assign br_b_sel    = src_sel[3];
  assign st_data_sel = mem_is_store && wb_reg_we && (wb_rd != '0) && (wb_rd == mem_rs2);
  assign stall_hold  = stall;
  assign idex_bubble = stall;
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic          id_is_branch,
  input logic          id_is_store,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rs2,
  input logic [AW-1:0] ex_rd,
  input logic          ex_reg_we,
  input logic          ex_is_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_reg_we,
  input logic          mem_is_load,
  input logic          mem_is_store,
  input logic [AW-1:0] mem_rs2,
  input logic [AW-1:0] wb_rd,
  input logic          wb_reg_we,
  input logic [1:0]    alu_a_sel,
  input logic [1:0]    alu_b_sel,
  input logic          st_data_sel,
  input logic [1:0]    br_a_sel,
  input logic [1:0]    br_b_sel,
  input logic          stall_hold,
  input logic          idex_bubble
);
  always_comb begin
    AST_SEL_CODE_LEGAL: assert (alu_a_sel != 2'b11 && alu_b_sel != 2'b11 && br_a_sel != 2'b11 && br_b_sel != 2'b11); // R1
    AST_YOUNGER_WINS: assert (!(mem_reg_we && mem_rd != '0 && mem_rd == ex_rs1) || alu_a_sel == 2'b10); // R2
    AST_ZERO_SRC_FROM_RF: assert (ex_rs1 != '0 || alu_a_sel == 2'b00); // R3
    AST_LOAD_USE_STALLS: assert (!(ex_is_load && ex_reg_we && ex_rd != '0 && ex_rd == id_rs1) || stall_hold); // R4
    AST_STORE_DATA_NO_STALL: assert (!(id_is_store && !id_is_branch && ex_is_load && id_rs1 != ex_rd && !(mem_reg_we && mem_is_load)) || !stall_hold); // R5
    AST_BRANCH_ALU_STALLS: assert (!(id_is_branch && ex_reg_we && ex_rd != '0 && ex_rd == id_rs2) || stall_hold); // R6
    AST_HOLD_EQ_BUBBLE: assert (stall_hold == idex_bubble); // R9
    AST_WE_LOW_NO_WB_FWD: assert (wb_reg_we || (alu_a_sel != 2'b01 && !st_data_sel)); // R10
  end
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/hazard_fwd_unit_bench.sv
module hazard_fwd_unit_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
  logic id_is_branch, id_is_store, ex_reg_we, ex_is_load;
  logic mem_reg_we, mem_is_load, mem_is_store, wb_reg_we;
  logic [1:0] alu_a_sel, alu_b_sel, br_a_sel, br_b_sel;
  logic st_data_sel, stall_hold, idex_bubble;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  hazard_fwd_unit #(.AW(AW)) u_hazard_fwd_unit (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected select from the requirement text
  function automatic int exp_sel(input int src, input bit skip_ld);
    if (src != 0 && mem_reg_we && !(skip_ld && mem_is_load) && int'(mem_rd) == src) return 2;
    if (src != 0 && wb_reg_we && int'(wb_rd) == src) return 1;
    return 0;
  endfunction

  // bench-side operand mux: rf=100+i, wb=300+i, exmem=200+i
  function automatic int mux_val(input int sel, input int src);
    case (sel)
      2: return 200 + src;
      1: return 300 + src;
      default: return 100 + src;
    endcase
  endfunction

  function automatic int youngest_val(input int src);
    if (src == 0) return 100;
    if (mem_reg_we && int'(mem_rd) == src) return 200 + src;
    if (wb_reg_we && int'(wb_rd) == src) return 300 + src;
    return 100 + src;
  endfunction

  function automatic int exp_stall();
    bit exm1, exm2, mm1, mm2;
    exm1 = ex_reg_we && ex_rd != 0 && ex_rd == id_rs1;
    exm2 = ex_reg_we && ex_rd != 0 && ex_rd == id_rs2;
    mm1  = mem_reg_we && mem_is_load && mem_rd != 0 && mem_rd == id_rs1;
    mm2  = mem_reg_we && mem_is_load && mem_rd != 0 && mem_rd == id_rs2;
    if (ex_is_load && (exm1 || (exm2 && !id_is_store))) return 1;
    if (id_is_branch && (exm1 || exm2 || mm1 || mm2)) return 1;
    return 0;
  endfunction

  task automatic check_all();
    int es;
    chk("R1 alu_a_sel", alu_a_sel, exp_sel(ex_rs1, 1'b0));
    chk("R1 alu_b_sel", alu_b_sel, exp_sel(ex_rs2, 1'b0));
    chk("R2 alu_a value", mux_val(alu_a_sel, ex_rs1), youngest_val(ex_rs1));
    chk("R2 alu_b value", mux_val(alu_b_sel, ex_rs2), youngest_val(ex_rs2));
    chk("R8 br_a_sel", br_a_sel, exp_sel(id_rs1, 1'b1));
    chk("R8 br_b_sel", br_b_sel, exp_sel(id_rs2, 1'b1));
    chk("R5 st_data_sel", st_data_sel,
        int'(mem_is_store && wb_reg_we && wb_rd != 0 && wb_rd == mem_rs2));
    es = exp_stall();
    chk("R4 R6 R7 stall_hold", stall_hold, es);
    chk("R9 idex_bubble", idex_bubble, es);
  endtask

  task automatic clear_inputs();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd} = '0;
    {id_is_branch, id_is_store, ex_reg_we, ex_is_load} = '0;
    {mem_reg_we, mem_is_load, mem_is_store, wb_reg_we} = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    clear_inputs();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // reset state: idle pipe gives no bypass, no stall
    chk("R9 idle hold", stall_hold, 0);
    chk("R1 idle alu_a", alu_a_sel, 0);

    // directed: branch behind ALU op -> 1 stall; R6
    @(negedge clk); clear_inputs();
    id_is_branch = 1; id_rs1 = 5'd7; ex_rd = 5'd7; ex_reg_we = 1;
    @(posedge clk); #1; chk("R6 branch after alu", stall_hold, 1);
    @(negedge clk); clear_inputs();
    id_is_branch = 1; id_rs1 = 5'd7; mem_rd = 5'd7; mem_reg_we = 1;
    @(posedge clk); #1;
    chk("R6 released", stall_hold, 0);
    chk("R8 branch takes exmem", br_a_sel, 2);
    // branch behind load: second stall then MEM/WB; R7
    @(negedge clk); clear_inputs();
    id_is_branch = 1; id_rs2 = 5'd9; mem_rd = 5'd9; mem_reg_we = 1; mem_is_load = 1;
    @(posedge clk); #1; chk("R7 second stall", stall_hold, 1);
    @(negedge clk); clear_inputs();
    id_is_branch = 1; id_rs2 = 5'd9; wb_rd = 5'd9; wb_reg_we = 1;
    @(posedge clk); #1;
    chk("R7 released", stall_hold, 0);
    chk("R8 branch takes wb", br_b_sel, 1);
    // R3 zero destination ignored
    @(negedge clk); clear_inputs();
    id_is_branch = 1; ex_reg_we = 1; ex_is_load = 1; mem_reg_we = 1; wb_reg_we = 1;
    @(posedge clk); #1;
    chk("R3 zero no stall", stall_hold, 0);
    chk("R3 zero no fwd", alu_a_sel, 0);
    // R10 write-enable low
    @(negedge clk); clear_inputs();
    ex_rs1 = 5'd3; mem_rd = 5'd3; wb_rd = 5'd3;
    @(posedge clk); #1; chk("R10 we low no fwd", alu_a_sel, 0);

    // sweep: indices 0..3 so collisions are frequent
    lf = 32'h1D2C_3B4A;
    for (int v = 0; v < 30000; v++) begin
      @(negedge clk);
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      id_rs1  = AW'(lf[1:0]);   id_rs2  = AW'(lf[3:2]);
      ex_rs1  = AW'(lf[5:4]);   ex_rs2  = AW'(lf[7:6]);
      ex_rd   = AW'(lf[9:8]);   mem_rd  = AW'(lf[11:10]);
      wb_rd   = AW'(lf[13:12]); mem_rs2 = AW'(lf[15:14]);
      id_is_branch = lf[16]; id_is_store = lf[17] && !lf[16];
      ex_is_load   = lf[18]; ex_reg_we   = lf[18] | lf[19];
      mem_is_load  = lf[20]; mem_is_store = lf[21] && !lf[20];
      mem_reg_we   = lf[20] | (lf[22] && !mem_is_store);
      wb_reg_we    = lf[23];
      @(posedge clk); #1;
      check_all();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule